// File: doc/BRIEF.md
# Bit-Serial Binary Associative Recall Engine

This block runs recall on a binary associative memory of `N_UNITS` units. Each row of the binary weight matrix sits in its own closed shift loop, and the unit states sit in one further loop. While the engine runs, every loop rotates by one position per cycle. In each cycle, the state bit leaving the state loop is ANDed with the weight bit leaving every row loop, and one accumulator per row adds up that product. After `N_UNITS` cycles each accumulator holds the dot product of its row with the state vector. Each result is then compared with a threshold, and the new state vector is written back into the state loop in the same edge.

A host loads the contents while the engine is idle. It shifts one bit per cycle into every row loop and into the state loop. Then it presents a threshold and pulses `start`. The engine runs passes until a pass leaves the state vector unchanged, or until `MAX_ITER` passes have run. A one-cycle `done` pulse follows every pass. The state vector can be read in parallel whenever the engine is idle.

Top module: `assoc_recall`

## Requirements
- R1: While idle, each cycle with `load_en` high shifts `load_w[i]` into row loop i and `load_s` into the state loop. After `N_UNITS` such cycles, the k-th bit loaded (counting from 0) is column k of every row and unit k of the state. `state_out[k]` shows unit k, so the first state bit loaded appears at `state_out[0]`. While idle with `load_en` low, `state_out` holds its value.
- R2: A cycle with `start` high, `load_en` low and the engine idle makes `busy` high from the next cycle on. The `thresh` value of that cycle is captured as the threshold for the whole run.
- R3: Each pass lasts exactly `N_UNITS` cycles. `done` is high for exactly one cycle after the last edge of every pass, so done pulses occur `N_UNITS`, `2*N_UNITS`, ... cycles after the start edge.
- R4: After a pass, unit i becomes 1 exactly when the number of positions k with row i column k = 1 and unit k = 1 is at least the captured threshold. Otherwise unit i becomes 0.
- R5: A threshold of 0 makes every unit 1 after a pass. A threshold above `N_UNITS` makes every unit 0.
- R6: With `EARLY_STOP` = 1 (the default), a pass that leaves the state vector unchanged ends the run: `busy` falls in the same cycle that `done` is high.
- R7: A run never performs more than `MAX_ITER` passes. After the `MAX_ITER`-th pass, `busy` falls with that pass's `done`.
- R8: When `start` and `load_en` are both high in the same idle cycle, the load takes place and the start is ignored: `busy` stays low.
- R9: `start` and `load_en` have no effect while `busy` is high. The loops and the result of the run are unchanged.
- R10: After reset, `busy` and `done` are 0, and all loops, and therefore `state_out`, are 0.
- R11: Changes on `thresh` while `busy` is high have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Shift load bits into the loops (idle only) |
| load_w | input | N_UNITS | One weight bit per row loop |
| load_s | input | 1 | State bit for the state loop |
| start | input | 1 | Begin a recall run (idle only) |
| thresh | input | $clog2(N_UNITS+1) | Threshold, captured at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after each pass |
| state_out | output | N_UNITS | Parallel view of the state loop, bit k = unit k |

## Verification
Two collisions are provoked. The first is a load and a start in the same idle cycle. The bench drives both together and then judges, one cycle later, that `busy` is still low and that `state_out` has shifted by exactly one new bit. The second is a stray start, load or threshold change landing in the middle of a pass. Here the bench judges the pass count, the done timing and the final state against a reference model of the recall iteration. The model receives only the contents loaded before the run, so any disturbance that leaked in would show up as a mismatch.

// File: rtl/assoc_recall_pkg.sv
package assoc_recall_pkg;
   // accumulator width able to hold a count of 0..n
   function automatic int acc_width(input int n);
      return $clog2(n + 1);
   endfunction
   // width of a counter that runs 0..n-1 (at least one bit)
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rcl_shift_loop.sv
module rcl_shift_loop #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         shift_in,
   input  logic         din,
   input  logic         rot,
   output logic [W-1:0] q
);
   // bit 0 is the exit end; rotation feeds it back in at the top
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (wr)       q <= wdata;
      else if (shift_in) q <= {din, q[W-1:1]};
      else if (rot)      q <= {q[0], q[W-1:1]};
   end
endmodule

// File: rtl/rcl_lane.sv
module rcl_lane #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic          wbit,
   input  logic          sbit,
   input  logic [AW-1:0] thr,
   output logic          fire
);
   logic [AW-1:0] acc;
   logic [AW-1:0] sum;

   assign sum  = acc + {{(AW-1){1'b0}}, (wbit & sbit)};
   assign fire = (sum >= thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (clr)  acc <= '0;
      else if (step) acc <= sum;
   end
endmodule

// File: rtl/rcl_ctrl.sv
module rcl_ctrl #(
   parameter int N_UNITS  = 8,
   parameter int MAX_ITER = 4,
   parameter int AW       = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          load_en,
   input  logic [AW-1:0] thr_in,
   input  logic          changed,
   output logic          busy,
   output logic          last,
   output logic          clr,
   output logic          done,
   output logic [AW-1:0] thr_q
);
   localparam int CW = assoc_recall_pkg::idx_width(N_UNITS);
   localparam int IW = assoc_recall_pkg::acc_width(MAX_ITER);
   localparam logic [CW-1:0] CNT_LAST = CW'(N_UNITS - 1);
   localparam logic [IW-1:0] ITER_LAST = IW'(MAX_ITER - 1);

   logic [CW-1:0] cnt;
   logic [IW-1:0] iter;

   assign last = busy && (cnt == CNT_LAST);
   assign clr  = !busy || last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt   <= '0;
         iter  <= '0;
         done  <= 1'b0;
         thr_q <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start && !load_en) begin
               busy  <= 1'b1;
               cnt   <= '0;
               iter  <= '0;
               thr_q <= thr_in;
            end
         end else if (cnt == CNT_LAST) begin
            done <= 1'b1;
            cnt  <= '0;
            iter <= iter + 1'b1;
            if (!changed || (iter == ITER_LAST)) busy <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/assoc_recall.sv
module assoc_recall #(
   parameter int N_UNITS    = 8,
   parameter int MAX_ITER   = 4,
   parameter bit EARLY_STOP = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load_en,
   input  logic [N_UNITS-1:0]             load_w,
   input  logic                           load_s,
   input  logic                           start,
   input  logic [$clog2(N_UNITS+1)-1:0]   thresh,
   output logic                           busy,
   output logic                           done,
   output logic [N_UNITS-1:0]             state_out
);
   localparam int AW = assoc_recall_pkg::acc_width(N_UNITS);

   if (N_UNITS < 2) begin : g_bad_units
      $error("assoc_recall: N_UNITS must be at least 2");
   end
   if (MAX_ITER < 1) begin : g_bad_iter
      $error("assoc_recall: MAX_ITER must be at least 1");
   end

   logic              last;
   logic              clr;
   logic              changed;
   logic              load_ok;
   logic [AW-1:0]     thr_q;
   logic [N_UNITS-1:0] s_q;
   logic [N_UNITS-1:0] new_vec;
   logic [N_UNITS-1:0] old_vec;
   logic [N_UNITS-1:0] w_tail;

   assign load_ok   = load_en && !busy;
   assign state_out = s_q;
   // one more rotation would restore the pass-start alignment
   assign old_vec   = {s_q[0], s_q[N_UNITS-1:1]};

   if (EARLY_STOP) begin : g_stop_stable
      assign changed = (new_vec != old_vec);
   end else begin : g_run_full
      assign changed = 1'b1;
   end

   rcl_ctrl #(
      .N_UNITS (N_UNITS),
      .MAX_ITER(MAX_ITER),
      .AW      (AW)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .load_en(load_en),
      .thr_in (thresh),
      .changed(changed),
      .busy   (busy),
      .last   (last),
      .clr    (clr),
      .done   (done),
      .thr_q  (thr_q)
   );

   rcl_shift_loop #(.W(N_UNITS)) u_state_loop (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (last),
      .wdata   (new_vec),
      .shift_in(load_ok),
      .din     (load_s),
      .rot     (busy),
      .q       (s_q)
   );

   for (genvar i = 0; i < N_UNITS; i++) begin : g_row
      logic [N_UNITS-1:0] w_q;

      rcl_shift_loop #(.W(N_UNITS)) u_wloop (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (1'b0),
         .wdata   ({N_UNITS{1'b0}}),
         .shift_in(load_ok),
         .din     (load_w[i]),
         .rot     (busy),
         .q       (w_q)
      );
      assign w_tail[i] = w_q[0];

      rcl_lane #(.AW(AW)) u_lane (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (clr),
         .step (busy),
         .wbit (w_tail[i]),
         .sbit (s_q[0]),
         .thr  (thr_q),
         .fire (new_vec[i])
      );
   end
endmodule

// File: rtl/assoc_recall_chk.sv
module assoc_recall_chk #(
   parameter int N_UNITS  = 8,
   parameter int MAX_ITER = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               load_en,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic [N_UNITS-1:0] state_out
);
   int pass_cyc;
   int pass_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass_cyc <= 0;
         pass_cnt <= 0;
      end else begin
         if (done)      pass_cyc <= busy ? 1 : 0;
         else if (busy) pass_cyc <= pass_cyc + 1;
         else           pass_cyc <= 0;

         if (!busy && start && !load_en) pass_cnt <= 0;
         else if (done)                  pass_cnt <= pass_cnt + 1;
      end
   end

   // R3: a pass spans exactly N_UNITS busy cycles before its done
   assert_pass_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pass_cyc == N_UNITS));

   // R3: done never lasts two cycles
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6/R7: the run can only end together with a done
   assert_stop_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R7: pass count of a run is bounded
   assert_iter_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pass_cnt <= MAX_ITER);

   // R8: a run begins only from a start without a load
   assert_start_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(start) && !$past(load_en)));

   // R1: idle with no load keeps the state loop still
   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load_en) |=> $stable(state_out));
endmodule

bind assoc_recall assoc_recall_chk #(
   .N_UNITS (N_UNITS),
   .MAX_ITER(MAX_ITER)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .load_en  (load_en),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .state_out(state_out)
);

// File: tb/tb_assoc_recall.sv
module tb_assoc_recall;
   localparam int N  = 8;
   localparam int MI = 4;
   localparam int NV = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load_en = 1'b0;
   logic [N-1:0] load_w = '0;
   logic         load_s = 1'b0;
   logic         start = 1'b0;
   logic [3:0]   thresh = '0;
   logic         busy;
   logic         done;
   logic [N-1:0] state_out;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   // stimulus table: weights (row i = bits [8i+:8], bit k = column k), start state, threshold
   localparam logic [63:0] VW [NV] = '{
      64'h8040201008040201, 64'hFFFFFFFFFFFFFFFF, 64'h0180402010080402,
      64'hFFFFFFFFFFFFFFFF, 64'h3C5A99660FF0A5C3 };
   localparam logic [7:0] VS [NV] = '{8'hA5, 8'h01, 8'h01, 8'h0F, 8'h6B};
   localparam logic [3:0] VT [NV] = '{4'd1, 4'd1, 4'd1, 4'd5, 4'd2};

   assoc_recall #(.N_UNITS(N), .MAX_ITER(MI)) dut (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_w(load_w),
      .load_s(load_s), .start(start), .thresh(thresh), .busy(busy),
      .done(done), .state_out(state_out));

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void model(input logic [63:0] w, input logic [7:0] s0,
                                 input logic [3:0] t, output logic [7:0] sf,
                                 output int np);
      logic [7:0] s;
      logic [7:0] nw;
      s = s0;
      np = 0;
      for (int it = 0; it < MI; it++) begin
         for (int i = 0; i < N; i++)
            nw[i] = ($countones(w[i*8 +: 8] & s) >= int'(t));
         np++;
         if (nw == s) break;
         s = nw;
      end
      sf = nw;
   endfunction

   task automatic load_all(input logic [63:0] w, input logic [7:0] s);
      for (int k = 0; k < N; k++) begin
         @(negedge clk);
         load_en = 1'b1;
         load_s  = s[k];
         for (int i = 0; i < N; i++) load_w[i] = w[i*8 + k];
      end
      @(negedge clk);
      load_en = 1'b0;
      load_w  = '0;
      load_s  = 1'b0;
   endtask

   // mode 0: clean, 1: stray start/load mid-pass, 2: threshold change mid-pass
   task automatic run(input logic [63:0] w, input logic [7:0] s, input logic [3:0] t,
                      input int mode, input string tag);
      logic [7:0] exp_s;
      int exp_np;
      int c;
      int np;
      model(w, s, t, exp_s, exp_np);
      load_all(w, s);
      chk(state_out == s, "R1 load order", state_out, s);
      thresh = t;
      start  = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      c = 0;
      np = 0;
      while (c < 1000) begin
         if (mode == 1 && c == 3) begin
            start = 1'b1; load_en = 1'b1; load_w = 8'hFF; load_s = 1'b1;
         end else if (mode == 1 && c == 4) begin
            start = 1'b0; load_en = 1'b0; load_w = '0; load_s = 1'b0;
         end
         if (mode == 2 && c == 2) thresh = (t == 0) ? 4'd9 : 4'd0;
         @(negedge clk);
         c++;
         if (done) begin
            np++;
            chk(c == np * N, {"R3 done timing ", tag}, c, np * N);
         end
         if (!busy) break;
      end
      thresh = t;
      chk(np == exp_np, {"R6/R7 pass count ", tag}, np, exp_np);
      chk(state_out == exp_s, {"R4 final state ", tag}, state_out, exp_s);
      @(negedge clk);
      chk(done == 1'b0, {"R3 single done ", tag}, done, 0);
   endtask

   initial begin
      logic [7:0] prev;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(busy == 1'b0, "R10 busy", busy, 0);
      chk(done == 1'b0, "R10 done", done, 0);
      chk(state_out == '0, "R10 state", state_out, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R4, R6 (early stop), R7 (cap with rotating pattern)
      for (int v = 0; v < NV; v++) run(VW[v], VS[v], VT[v], 0, $sformatf("v%0d", v));

      // R5 threshold extremes
      run(64'h0000000000000000, 8'h00, 4'd0, 0, "R5 t0");
      chk(state_out == 8'hFF, "R5 zero threshold all ones", state_out, 8'hFF);
      run(64'hFFFFFFFFFFFFFFFF, 8'hFF, 4'd9, 0, "R5 t9");
      chk(state_out == 8'h00, "R5 high threshold all zeros", state_out, 8'h00);

      // R9 stray start and load during a run
      run(64'h3C5A99660FF0A5C3, 8'h6B, 4'd2, 1, "R9");
      // R11 threshold change during a run
      run(64'hFFFFFFFFFFFFFFFF, 8'h0F, 4'd5, 2, "R11");

      // R8 load and start together while idle
      load_all(64'h0, 8'h5A);
      prev = state_out;
      @(negedge clk);
      load_en = 1'b1; start = 1'b1; load_s = 1'b1; load_w = '0;
      @(negedge clk);
      load_en = 1'b0; start = 1'b0; load_s = 1'b0;
      chk(busy == 1'b0, "R8 start ignored", busy, 0);
      chk(state_out == {1'b1, prev[7:1]}, "R8 load taken", state_out, {1'b1, prev[7:1]});
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && state_out == {1'b1, prev[7:1]}, "R1 idle hold",
          state_out, {1'b1, prev[7:1]});

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule